// File: doc/BRIEF.md
# Scoped TLB Invalidation Engine

This block sits beside each core's instruction TLB (ITB) and data TLB (DTB). Both are small and fully associative. Each entry carries a valid flag, a virtual page number and an address-space number (ASN). When the core's interrupt slot presents a shootdown command, the engine decodes its scope and clears every matching entry in the selected TLB or TLBs. In the same step it drops the core's load-locked reservation. It then raises an acknowledgment toward the coordinating core.

The scope is one of five choices:

- one virtual page, in the instruction side only;
- one virtual page, in the data side only;
- one virtual page, in both sides;
- every entry of one ASN, in both sides;
- everything, in both sides.

All entries are compared in parallel, so the invalidation lands at the first clock edge after the command is seen. The acknowledgment follows from that edge, so no stale entry is ever visible while the acknowledgment is high. A simple write port loads entries and a lookup port probes them for test purposes.

Top module: `tlb_shootdown_engine`

## Requirements
- R1: After reset every entry in both TLBs is invalid, `ack` is low and `rsv_valid` is low.
- R2: Command code 1 clears every valid ITB entry whose page number equals `slot_vpn`, whatever its ASN, and leaves the DTB unchanged.
- R3: Command code 2 clears every valid DTB entry whose page number equals `slot_vpn`, whatever its ASN, and leaves the ITB unchanged.
- R4: Command code 3 clears every entry in both TLBs whose page number equals `slot_vpn`, whatever its ASN.
- R5: Command code 4 clears every entry in both TLBs whose ASN equals `slot_asn`, whatever its page number.
- R6: Command code 5 clears every entry in both TLBs.
- R7: Command codes 0, 6 and 7 are acknowledged. They change no entry and do not touch the reservation.
- R8: Each of the commands with codes 1 to 5 clears the reservation. If `rsv_set` is high in the same cycle as the command, the clear wins.
- R9: A command is accepted in a cycle where `slot_valid` is high and `ack` is low. `ack` rises at the next edge, with the invalidation already applied. It stays high while `slot_valid` stays high and falls at the edge after `slot_valid` drops.
- R10: While `ack` is high, the slot contents are ignored and no command is accepted.
- R11: A lookup in the same cycle as an accepted command reports a miss for every entry that command invalidates.
- R12: A lookup hits in a TLB only on a valid entry whose page number and ASN both equal the probe. A write through the fill port makes its entry valid from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | Shootdown command present in the slot |
| slot_cmd | input | 3 | Scope code (see R2 to R7) |
| slot_vpn | input | 19 | Target page number for single-page commands |
| slot_asn | input | 8 | Target ASN for the ASN command |
| ack | output | 1 | Command completed, held until the slot is released |
| fill_en | input | 1 | Write one TLB entry |
| fill_tlb | input | 1 | Which TLB to write: 0 is the ITB, 1 is the DTB |
| fill_idx | input | 3 | Entry index to write |
| fill_vpn | input | 19 | Page number written |
| fill_asn | input | 8 | ASN written |
| lk_vpn | input | 19 | Lookup page number |
| lk_asn | input | 8 | Lookup ASN |
| lk_itb_hit | output | 1 | Lookup hit in the ITB |
| lk_dtb_hit | output | 1 | Lookup hit in the DTB |
| rsv_set | input | 1 | Load-locked reservation taken |
| rsv_valid | output | 1 | Reservation outstanding |

## Verification
A lookup can fall in the same cycle as the edge that accepts an invalidation. The bench provokes this on every command: in the cycle it presents the command, it also probes a page that the command removes. It expects a miss in that cycle, and it expects the acknowledgment to still be low. A reservation set can also coincide with a command's reservation clear. The bench raises both in the flush-all cycle and expects the reservation to be gone at the next sample. After each command, every stored entry is probed and compared with a model that applies the scope rules on its own.

// File: rtl/tlb_shootdown_engine.sv
module tlb_shootdown_engine #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int ASN_W   = 8,
  parameter int CMD_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_valid,
  input  logic [CMD_W-1:0] slot_cmd,
  input  logic [VPN_W-1:0] slot_vpn,
  input  logic [ASN_W-1:0] slot_asn,
  output logic             ack,
  input  logic             fill_en,
  input  logic             fill_tlb,
  input  logic [$clog2(ENTRIES)-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [ASN_W-1:0] fill_asn,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             lk_itb_hit,
  output logic             lk_dtb_hit,
  input  logic             rsv_set,
  output logic             rsv_valid
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [CMD_W-1:0] C_VA_I = CMD_W'(1);
  localparam logic [CMD_W-1:0] C_VA_D = CMD_W'(2);
  localparam logic [CMD_W-1:0] C_VA_B = CMD_W'(3);
  localparam logic [CMD_W-1:0] C_ASN  = CMD_W'(4);
  localparam logic [CMD_W-1:0] C_ALL  = CMD_W'(5);

  logic busy_q, rsv_q;
  logic accept, is_inval;
  logic c_va_i, c_va_d, c_va_b, c_asn, c_all;
  logic [1:0] sel_va;
  logic [1:0][ENTRIES-1:0] vld, kill, hitv;

  assign accept   = slot_valid & ~busy_q;
  assign c_va_i   = slot_cmd == C_VA_I;
  assign c_va_d   = slot_cmd == C_VA_D;
  assign c_va_b   = slot_cmd == C_VA_B;
  assign c_asn    = slot_cmd == C_ASN;
  assign c_all    = slot_cmd == C_ALL;
  assign is_inval = c_va_i | c_va_d | c_va_b | c_asn | c_all;
  assign sel_va[0] = c_va_i | c_va_b;
  assign sel_va[1] = c_va_d | c_va_b;

  for (genvar t = 0; t < 2; t++) begin : g_tlb
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic             v_r;
      logic [VPN_W-1:0] vpn_r;
      logic [ASN_W-1:0] asn_r;
      logic             wr;

      assign wr = fill_en && (fill_tlb == t[0]) && (fill_idx == IDX_W'(i));
      assign vld[t][i]  = v_r;
      assign kill[t][i] = accept & v_r &
                          (c_all | (c_asn & (asn_r == slot_asn)) |
                           (sel_va[t] & (vpn_r == slot_vpn)));
      assign hitv[t][i] = v_r & ~kill[t][i] & (vpn_r == lk_vpn) & (asn_r == lk_asn);

      always_ff @(posedge clk) begin
        if (!rst_n)          v_r <= 1'b0;
        else if (kill[t][i]) v_r <= 1'b0;
        else if (wr)         v_r <= 1'b1;
      end

      always_ff @(posedge clk) begin
        if (wr) begin
          vpn_r <= fill_vpn;
          asn_r <= fill_asn;
        end
      end
    end
  end

  assign lk_itb_hit = |hitv[0];
  assign lk_dtb_hit = |hitv[1];

  always_ff @(posedge clk) begin
    if (!rst_n)           busy_q <= 1'b0;
    else if (accept)      busy_q <= 1'b1;
    else if (!slot_valid) busy_q <= 1'b0;
  end
  assign ack = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  rsv_q <= 1'b0;
    else if (accept && is_inval) rsv_q <= 1'b0;
    else if (rsv_set)            rsv_q <= 1'b1;
  end
  assign rsv_valid = rsv_q;

  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) accept |=> ack); // R9
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n) ack && slot_valid |=> ack); // R9
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) ack && !slot_valid |=> !ack); // R9
  AST_RSV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) accept && is_inval |=> !rsv_valid); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) accept && c_all |=> vld == '0); // R6
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) ack && !fill_en |=> $stable(vld)); // R10
  AST_SAME_CYCLE_MISS: assert property (@(posedge clk) disable iff (!rst_n) accept && c_all |-> !lk_itb_hit && !lk_dtb_hit); // R11
  AST_ITB_ONLY: assert property (@(posedge clk) disable iff (!rst_n) accept && c_va_i && !fill_en |=> $stable(vld[1])); // R2
  AST_DTB_ONLY: assert property (@(posedge clk) disable iff (!rst_n) accept && c_va_d && !fill_en |=> $stable(vld[0])); // R3
endmodule

// File: tb/tlb_shootdown_engine_tb_top.sv
`timescale 1ns/1ps
module tlb_shootdown_engine_tb_top;
  localparam int N = 8, VW = 19, AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slot_valid = 1'b0;
  logic [2:0] slot_cmd = '0;
  logic [VW-1:0] slot_vpn = '0, fill_vpn = '0, lk_vpn = '0;
  logic [AW-1:0] slot_asn = '0, fill_asn = '0, lk_asn = '0;
  logic fill_en = 1'b0, fill_tlb = 1'b0, rsv_set = 1'b0;
  logic [2:0] fill_idx = '0;
  logic ack, lk_itb_hit, lk_dtb_hit, rsv_valid;

  tlb_shootdown_engine dut_i (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_cmd(slot_cmd),
    .slot_vpn(slot_vpn), .slot_asn(slot_asn), .ack(ack), .fill_en(fill_en),
    .fill_tlb(fill_tlb), .fill_idx(fill_idx), .fill_vpn(fill_vpn), .fill_asn(fill_asn),
    .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_itb_hit(lk_itb_hit), .lk_dtb_hit(lk_dtb_hit),
    .rsv_set(rsv_set), .rsv_valid(rsv_valid));

  always #2 clk = ~clk;

  logic          m_v   [2][N];
  logic [VW-1:0] m_vpn [2][N];
  logic [AW-1:0] m_asn [2][N];
  logic          m_rsv = 1'b0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  function automatic logic mhit(int t, logic [VW-1:0] v, logic [AW-1:0] a);
    logic h = 1'b0;
    for (int i = 0; i < N; i++)
      if (m_v[t][i] && m_vpn[t][i] == v && m_asn[t][i] == a) h = 1'b1;
    return h;
  endfunction

  task automatic push(logic ack_e, string tag);
    exp_q.push_back({ack_e, m_rsv, mhit(0, lk_vpn, lk_asn), mhit(1, lk_vpn, lk_asn)});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      logic [3:0] e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if ({ack, rsv_valid, lk_itb_hit, lk_dtb_hit} !== e) begin
        errors++;
        $display("FAIL %s: {ack,rsv,ihit,dhit} got %b expected %b", tg,
                 {ack, rsv_valid, lk_itb_hit, lk_dtb_hit}, e);
      end
    end
  end

  task automatic look(logic [VW-1:0] v, logic [AW-1:0] a, logic ack_e, string tag);
    @(negedge clk);
    lk_vpn = v; lk_asn = a;
    push(ack_e, tag);
  endtask

  task automatic fill(int t, int idx, logic [VW-1:0] v, logic [AW-1:0] a);
    @(negedge clk);
    fill_en = 1'b1; fill_tlb = t[0]; fill_idx = idx[2:0]; fill_vpn = v; fill_asn = a;
    @(negedge clk);
    fill_en = 1'b0;
    m_v[t][idx] = 1'b1; m_vpn[t][idx] = v; m_asn[t][idx] = a;
  endtask

  task automatic populate();
    for (int i = 0; i < N; i++) fill(0, i, VW'('h100 + i), AW'(i % 3));
    for (int i = 0; i < N; i++) fill(1, i, VW'('h100 + i), AW'(i % 2));
    fill(0, 5, VW'('h102), AW'(2));
  endtask

  task automatic take_rsv();
    @(negedge clk); rsv_set = 1'b1;
    @(negedge clk); rsv_set = 1'b0;
    m_rsv = 1'b1;
  endtask

  task automatic check_tlb(string tag);
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < N; i++) look(m_vpn[t][i], m_asn[t][i], 1'b0, tag);
  endtask

  task automatic command(logic [2:0] cmd, logic [VW-1:0] v, logic [AW-1:0] a,
                         logic [VW-1:0] pv, logic [AW-1:0] pa, logic set_r, string tag);
    logic inval;
    @(negedge clk);
    slot_valid = 1'b1; slot_cmd = cmd; slot_vpn = v; slot_asn = a;
    lk_vpn = pv; lk_asn = pa; rsv_set = set_r;
    inval = (cmd >= 3'd1) && (cmd <= 3'd5);
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < N; i++)
        if (m_v[t][i] && (cmd == 3'd5 || (cmd == 3'd4 && m_asn[t][i] == a) ||
            ((((t == 0) && (cmd == 3'd1 || cmd == 3'd3)) ||
              ((t == 1) && (cmd == 3'd2 || cmd == 3'd3))) && m_vpn[t][i] == v)))
          m_v[t][i] = 1'b0;
    push(1'b0, {tag, " R11 same-cycle lookup"});
    m_rsv = inval ? 1'b0 : (set_r ? 1'b1 : m_rsv);
    @(negedge clk);
    rsv_set = 1'b0; slot_cmd = 3'd5; slot_asn = ~a;
    push(1'b1, {tag, " R9 ack with entries cleared, R8 reservation"});
    @(negedge clk);
    push(1'b1, {tag, " R10 slot ignored while ack pending"});
    @(negedge clk);
    slot_valid = 1'b0;
    push(1'b1, {tag, " R9 ack held until release edge"});
    @(negedge clk);
    slot_cmd = 3'd0;
    push(1'b0, {tag, " R9 ack released"});
  endtask

  initial begin
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < N; i++) begin
        m_v[t][i] = 1'b0; m_vpn[t][i] = '0; m_asn[t][i] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look(VW'(0), AW'(0), 1'b0, "R1 reset state");
    look(VW'('h100), AW'(0), 1'b0, "R1 reset state empty");

    populate();
    check_tlb("R12 filled entries hit");
    look(VW'('h101), AW'(7), 1'b0, "R12 ASN mismatch misses");
    take_rsv();
    command(3'd1, VW'('h102), AW'(9), VW'('h102), AW'(2), 1'b0, "R2");
    check_tlb("R2 ITB only by page");

    populate(); take_rsv();
    command(3'd2, VW'('h103), AW'(9), VW'('h103), AW'(1), 1'b0, "R3");
    check_tlb("R3 DTB only by page");

    populate(); take_rsv();
    command(3'd3, VW'('h104), AW'(9), VW'('h104), AW'(0), 1'b0, "R4");
    check_tlb("R4 both by page");

    populate(); take_rsv();
    command(3'd4, VW'('h0), AW'(1), VW'('h101), AW'(1), 1'b0, "R5");
    check_tlb("R5 ASN in both");

    populate();
    command(3'd5, VW'('h0), AW'(0), VW'('h100), AW'(0), 1'b1, "R6 R8 clear beats set");
    check_tlb("R6 flush all");

    populate(); take_rsv();
    command(3'd6, VW'('h100), AW'(0), VW'('h100), AW'(0), 1'b0, "R7 code 6");
    command(3'd0, VW'('h101), AW'(1), VW'('h101), AW'(1), 1'b0, "R7 code 0");
    command(3'd7, VW'('h102), AW'(2), VW'('h102), AW'(2), 1'b0, "R7 code 7");
    check_tlb("R7 unknown codes change nothing");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule